// File: doc/BRIEF.md
# Scanline-Split Character RAM Bank Selector

This block drives bit 12 of an 8 KB character RAM so that a picture processor can show one 4 KB pattern set in the top part of the frame and another in the bottom part, with no CPU write and no interrupt in the middle of the frame. It watches the picture-processor address bus and its read strobe. Whenever a tile-name fetch begins, it captures address bit 9, which is the coarse-row bit that turns to 1 at tile row 16 (pixel line 128). The captured bit then selects the RAM half for every pattern fetch that follows.

An enable input comes from the bank register logic elsewhere in the design. While the enable is high, both pattern windows (0x0000–0x0FFF and 0x1000–0x1FFF) map onto the same half, chosen by the captured bit. The result is the lower half from line 240 through line 127 of the next frame, and the upper half from line 128 onward. While the enable is low, address bit 12 passes straight through. The capture register keeps tracking name fetches even while the enable is low, so switching the enable on in mid-frame picks the correct half at once.

Top module: `chr_split_bank`

## Requirements
- R1: A synchronous reset clears the captured bit to 0 and clears the strobe history. In the first cycle after reset, with the enable high, `chr_a12` is 0 for any address.
- R2: While `split_en` is 0, `chr_a12` equals `ppu_addr[12]` in the same cycle.
- R3: While `split_en` is 1, `chr_a12` equals the captured bit for addresses in both pattern windows, 0x0000–0x0FFF and 0x1000–0x1FFF.
- R4: A cycle in which `ppu_rd` is 1 and was 0 in the previous cycle is a leading edge. A leading edge with an address in 0x2000–0x2FFF, whose low 10 bits are below 0x3C0, loads `ppu_addr[9]` into the captured bit at that clock edge. The new value shows from the next cycle.
- R5: While `ppu_rd` stays high across cycles, no further capture takes place, even if the address moves to another name-fetch address.
- R6: A leading edge on an attribute-area address (low 10 bits 0x3C0–0x3FF, inside 0x2000–0x2FFF) leaves the captured bit unchanged.
- R7: A leading edge on an address outside 0x2000–0x2FFF (pattern space 0x0000–0x1FFF, or 0x3000–0x3FFF such as the palette) leaves the captured bit unchanged.
- R8: Captures take place whether or not `split_en` is set. After the enable rises, `chr_a12` shows the bit captured while it was low.
- R9: All four name tables at 0x2000, 0x2400, 0x2800 and 0x2C00 count as capture sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| split_en | input | 1 | Split mode enable from the bank register logic |
| ppu_addr | input | 14 | Picture-processor address bus |
| ppu_rd | input | 1 | Picture-processor read strobe, active high |
| chr_a12 | output | 1 | Character RAM address bit 12 |

## Verification
The hardest case to reach is a strobe that stays high while the address walks from one name-fetch address to another. With a correct design this makes no second capture, and only a design that captures on level instead of edge would react to it. The bench holds the strobe across several addresses with opposite bit 9, and it places attribute and palette reads between name fetches. A full frame sweep of fetch groups, each made of a name read, an attribute read and two pattern reads, runs the row-16 switchover and the row-0 switchback through all four name tables. All of this is checked every cycle against a behavioural model.

// File: rtl/chr_split_pkg.sv
package chr_split_pkg;

    localparam int ADDR_W   = 14;
    localparam int ROW_BIT  = 9;
    localparam int PASS_BIT = 12;

    localparam logic [ADDR_W-1:0] NAME_LO   = 14'h2000;
    localparam logic [ADDR_W-1:0] NAME_HI   = 14'h2FFF;
    localparam logic [9:0]        ATTR_BASE = 10'h3C0;

    typedef logic [ADDR_W-1:0] ppu_addr_t;

    typedef struct packed {
        logic rise;
        logic name_hit;
        logic row_bit;
    } fetch_t;

    function automatic logic is_name_fetch(input ppu_addr_t a);
        return (a >= NAME_LO) && (a <= NAME_HI) && (a[9:0] < ATTR_BASE);
    endfunction

endpackage

// File: rtl/chr_split_edge.sv
module chr_split_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic rise
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/chr_split_latch.sv
module chr_split_latch
    import chr_split_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  fetch_t fetch,
    output logic   half_sel
);
    always_ff @(posedge clk) begin
        if (rst)
            half_sel <= 1'b0;
        else if (fetch.rise && fetch.name_hit)
            half_sel <= fetch.row_bit;
    end
endmodule

// File: rtl/chr_split_mux.sv
module chr_split_mux (
    input  logic en,
    input  logic half_sel,
    input  logic addr_bit,
    output logic out_bit
);
    always_comb begin
        if (en) out_bit = half_sel;
        else    out_bit = addr_bit;
    end
endmodule

// File: rtl/chr_split_bank.sv
module chr_split_bank
    import chr_split_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              split_en,
    input  logic [ADDR_W-1:0] ppu_addr,
    input  logic              ppu_rd,
    output logic              chr_a12
);
    fetch_t fetch;
    logic   rise;
    logic   half_sel;

    chr_split_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (ppu_rd),
        .rise   (rise)
    );

    always_comb begin
        fetch.rise     = rise;
        fetch.name_hit = is_name_fetch(ppu_addr);
        fetch.row_bit  = ppu_addr[ROW_BIT];
    end

    chr_split_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .fetch    (fetch),
        .half_sel (half_sel)
    );

    chr_split_mux u_mux (
        .en       (split_en),
        .half_sel (half_sel),
        .addr_bit (ppu_addr[PASS_BIT]),
        .out_bit  (chr_a12)
    );
endmodule

// File: rtl/chr_split_bank_chk.sv
module chr_split_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic        split_en,
    input logic [13:0] ppu_addr,
    input logic        ppu_rd,
    input logic        chr_a12
);
    logic rd_seen;
    logic cap_edge;

    always_ff @(posedge clk) begin
        if (rst) rd_seen <= 1'b0;
        else     rd_seen <= ppu_rd;
    end

    assign cap_edge = ppu_rd && !rd_seen &&
                      (ppu_addr[13:12] == 2'b10) && (ppu_addr[9:6] != 4'hF);

    // R1
    a_r1_cleared: assert property (@(posedge clk)
        ($past(rst) && !rst && split_en) |-> !chr_a12);

    // R2
    a_r2_passthru: assert property (@(posedge clk) disable iff (rst)
        !split_en |-> (chr_a12 == ppu_addr[12]));

    // R4
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        cap_edge |=> (!split_en || chr_a12 == $past(ppu_addr[9])));

    // R5, R6, R7
    a_r5_stable_without_capture: assert property (@(posedge clk) disable iff (rst)
        (split_en && !cap_edge) |=> (!split_en || $stable(chr_a12)));
endmodule

bind chr_split_bank chr_split_bank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .split_en (split_en),
    .ppu_addr (ppu_addr),
    .ppu_rd   (ppu_rd),
    .chr_a12  (chr_a12)
);

// File: tb/chr_split_bank_bench.sv
module chr_split_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        split_en = 1'b0;
    logic [13:0] ppu_addr = 14'h0;
    logic        ppu_rd = 1'b0;
    logic        chr_a12;

    int vectors = 0;
    int errors  = 0;

    int m_sel  = 0;
    int m_prev = 0;

    always #2 clk = ~clk;

    chr_split_bank u_chr_split_bank (
        .clk      (clk),
        .rst      (rst),
        .split_en (split_en),
        .ppu_addr (ppu_addr),
        .ppu_rd   (ppu_rd),
        .chr_a12  (chr_a12)
    );

    function automatic bit model_hit(input int a);
        return (a >= 8192) && (a < 12288) && ((a % 1024) < 960);
    endfunction

    task automatic step(input bit r, input bit en, input int a, input bit rd,
                        input string req);
        int exp_v;
        @(negedge clk);
        rst = r; split_en = en; ppu_addr = a[13:0]; ppu_rd = rd;
        #1;
        if (!r) begin
            exp_v = en ? m_sel : ((a / 4096) % 2);
            vectors++;
            if (chr_a12 !== exp_v[0]) begin
                errors++;
                $display("FAIL %s addr=%h en=%0d rd=%0d actual=%0b expected=%0d",
                         req, a, en, rd, chr_a12, exp_v);
            end
        end
        @(posedge clk);
        if (r) begin
            m_sel = 0; m_prev = 0;
        end else begin
            if (rd && m_prev == 0 && model_hit(a)) m_sel = (a / 512) % 2;
            m_prev = rd;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        step(1, 1, 'h2200, 1, "R1");
        step(1, 1, 'h2200, 0, "R1");
        // R1: cleared selection, address bit 12 high
        step(0, 1, 'h1ABC, 0, "R1");
        step(0, 1, 'h0ABC, 0, "R1");
        // R2: pass-through
        step(0, 0, 'h0000, 0, "R2");
        step(0, 0, 'h1FFF, 0, "R2");
        step(0, 0, 'h1000, 0, "R2");
        step(0, 0, 'h0800, 0, "R2");
        // R4: capture bit 9 = 1, visible next cycle; R3 both windows
        step(0, 1, 'h2200, 1, "R4");
        step(0, 1, 'h0000, 0, "R3");
        step(0, 1, 'h1000, 0, "R3");
        // R5: strobe held high while address moves
        step(0, 1, 'h2000, 1, "R4");
        step(0, 1, 'h2200, 1, "R5");
        step(0, 1, 'h2000, 1, "R5");
        step(0, 1, 'h1000, 1, "R5");
        step(0, 1, 'h1000, 0, "R5");
        // R6: attribute area ignored
        step(0, 1, 'h23C0, 1, "R6");
        step(0, 1, 'h0000, 0, "R6");
        step(0, 1, 'h27FF, 1, "R6");
        step(0, 1, 'h1000, 0, "R6");
        // R7: palette and pattern reads ignored
        step(0, 1, 'h3F00, 1, "R7");
        step(0, 1, 'h0000, 0, "R7");
        step(0, 1, 'h1200, 1, "R7");
        step(0, 1, 'h1000, 0, "R7");
        step(0, 1, 'h3200, 1, "R7");
        step(0, 1, 'h0000, 0, "R7");
        // R9: other name tables
        step(0, 1, 'h2E00, 1, "R9");
        step(0, 1, 'h0000, 0, "R9");
        step(0, 1, 'h2800, 1, "R9");
        step(0, 1, 'h1000, 0, "R9");
        step(0, 1, 'h2600, 1, "R9");
        step(0, 1, 'h0000, 0, "R9");
        // R8: capture while disabled, then enable
        step(0, 0, 'h2400, 1, "R8");
        step(0, 0, 'h1000, 0, "R8");
        step(0, 1, 'h1000, 0, "R8");
        step(0, 0, 'h2A00, 1, "R8");
        step(0, 0, 'h0000, 0, "R8");
        step(0, 1, 'h0000, 0, "R8");
        // R3: frame sweeps across all tables
        for (int t = 0; t < 4; t++) begin
            for (int row = 0; row < 30; row++) begin
                for (int col = 0; col < 8; col++) begin
                    int nt = 8192 + t * 1024 + row * 32 + col * 4;
                    int at = 8192 + t * 1024 + 960 + (row / 4) * 8 + col;
                    int pt = ((row + col) % 2) * 4096 + row * 16 + col;
                    step(0, 1, nt, 1, "R3");
                    step(0, 1, nt, 0, "R3");
                    step(0, 1, at, 1, "R6");
                    step(0, 1, at, 0, "R6");
                    step(0, 1, pt, 1, "R3");
                    step(0, 1, pt, 0, "R3");
                    step(0, 1, pt + 8, 1, "R3");
                    step(0, 1, pt + 8, 0, "R3");
                end
            end
        end
        // mixed pseudo-random traffic
        for (int i = 0; i < 3000; i++) begin
            int a = $urandom % 16384;
            step(0, ($urandom % 4) != 0, a, $urandom % 2, "R4");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule